// File: doc/BRIEF.md
# Berger Code Encoder and Two-Rail Checker

This block protects an information field against unidirectional errors using a separable Berger code. The encoder side takes an information word and produces a check field. That check field is the binary count of the zero bits in the word. It is sent or stored alongside the information bits. The checker side takes a received information word and its received check field. It recounts the zeros and compares the two values bit by bit.

When every bit of a word flips in the same direction, the zero count and the check value always move apart, so the checker flags the word. This holds whether the bits flip only from 1 to 0 or only from 0 to 1, and whether the flips fall in the data bits, the check bits or both.

The verdict is given as a pair of rails instead of a single flag. A good word gives a complementary pair. The polarity of that pair follows a reference phase input that the system toggles, so a rail stuck at either level shows up during normal traffic. A bad word gives two equal rails. Both paths are combinational. A parameter selects an optional output register stage, which is on by default.

Top module: `berger_guard`

## Requirements
- R1: `enc_check_o` equals the number of zero bits in `enc_data_i`, as an unsigned binary value. The field is ceil(log2(DATA_W+1)) bits wide, which is 4 bits for the default DATA_W of 8.
- R2: An all-zero information word encodes to 8 (4'b1000). An all-one word encodes to 0.
- R3: If `rx_check_i` equals the zero count of `rx_data_i`, then `verdict_o` is a complementary pair. Bit 1 of `verdict_o` equals `phase_i` and bit 0 equals its inverse.
- R4: If `rx_check_i` differs from the zero count of `rx_data_i`, then both bits of `verdict_o` are equal, giving 2'b00 or 2'b11.
- R5: Take a valid 12-bit word {check, data}. Apply any non-empty set of flips that are all 1-to-0, or all 0-to-1. The result always yields the R4 error pattern.
- R6: Consider two consecutive valid words with a toggled `phase_i` between them. The two verdicts differ, alternating between 2'b10 and 2'b01.
- R7: With REG_OUT=1, both outputs change one clock after their inputs. While the synchronous active-high `rst` is held, the outputs are `enc_check_o`=0 and `verdict_o`=2'b01.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output stage |
| rst | input | 1 | Synchronous active-high reset |
| enc_data_i | input | DATA_W | Information word to encode |
| enc_check_o | output | CHK_W | Zero count of `enc_data_i` |
| rx_data_i | input | DATA_W | Received information word |
| rx_check_i | input | CHK_W | Received check field |
| phase_i | input | 1 | Reference phase that sets the polarity of a good verdict |
| verdict_o | output | 2 | Two-rail result: complementary = good, equal rails = error |

## Verification
The bound assertions check several rules on every clock:
- The encoder output is the zero count of the previous input word.
- A word whose check matches yields the phase-aligned complementary pair.
- Any mismatch gives equal rails.
- A toggled phase across two good words flips the verdict.
- Reset drives the idle values.

Unidirectional-error coverage is a property of the code rather than a rule tied to one cycle, so only the bench scenarios can show it. Those scenarios inject burst flips all in one direction across the data and check bits of many words. The bench also shows the all-zero and all-one encodings, and the one-clock hold of the registered outputs.

// File: rtl/berger_pkg.sv
package berger_pkg;

    localparam int DEF_DATA_W = 8;

    // One rail pair: a codeword when t != f
    typedef struct packed {
        logic t;
        logic f;
    } rail_pair_t;

    function automatic int chk_width(input int k);
        return $clog2(k + 1);
    endfunction

    // Merge two rail pairs: valid only if both inputs are valid
    function automatic rail_pair_t tr_merge(input rail_pair_t a, input rail_pair_t b);
        rail_pair_t z;
        z.t = (a.t & b.t) | (a.f & b.f);
        z.f = (a.t & b.f) | (a.f & b.t);
        return z;
    endfunction

    function automatic logic pair_ok(input rail_pair_t p);
        return p.t ^ p.f;
    endfunction

endpackage

// File: rtl/berger_zero_count.sv
module berger_zero_count #(
    parameter int DATA_W = 8,
    parameter int CHK_W  = 4
) (
    input  logic [DATA_W-1:0] data_i,
    output logic [CHK_W-1:0]  count_o
);
    logic [DATA_W-1:0] zero_flag;

    genvar gi;
    generate
        for (gi = 0; gi < DATA_W; gi++) begin : g_flag
            assign zero_flag[gi] = ~data_i[gi];
        end
    endgenerate

    always_comb begin
        count_o = '0;
        for (int i = 0; i < DATA_W; i++) begin
            count_o = count_o + {{(CHK_W-1){1'b0}}, zero_flag[i]};
        end
    end
endmodule

// File: rtl/berger_tr_cell.sv
module berger_tr_cell
    import berger_pkg::*;
(
    input  rail_pair_t a_i,
    input  rail_pair_t b_i,
    output rail_pair_t z_o
);
    assign z_o = tr_merge(a_i, b_i);
endmodule

// File: rtl/berger_checker.sv
module berger_checker
    import berger_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CHK_W  = 4
) (
    input  logic [DATA_W-1:0] rx_data_i,
    input  logic [CHK_W-1:0]  rx_check_i,
    input  logic              phase_i,
    output rail_pair_t        verdict_o
);
    // leaves: one per check bit, one parity leaf, one phase leaf
    localparam int NLEAF = CHK_W + 2;
    // each merge cell inverts the true-rail parity once
    localparam logic CHAIN_INV = 1'((NLEAF - 1) % 2);

    logic [CHK_W-1:0] recount;
    rail_pair_t       leaf [NLEAF];
    rail_pair_t       link [NLEAF];

    berger_zero_count #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_recount (
        .data_i  (rx_data_i),
        .count_o (recount)
    );

    always_comb begin
        for (int i = 0; i < CHK_W; i++) begin
            leaf[i].t = rx_check_i[i];
            leaf[i].f = ~recount[i];
        end
        // cancels the data-dependent parity of the check-bit leaves
        leaf[CHK_W].t   = ^recount;
        leaf[CHK_W].f   = ~(^recount);
        leaf[CHK_W+1].t = phase_i ^ CHAIN_INV;
        leaf[CHK_W+1].f = ~(phase_i ^ CHAIN_INV);
    end

    assign link[0] = leaf[0];

    genvar gj;
    generate
        for (gj = 1; gj < NLEAF; gj++) begin : g_chain
            berger_tr_cell u_cell (
                .a_i (link[gj-1]),
                .b_i (leaf[gj]),
                .z_o (link[gj])
            );
        end
    endgenerate

    assign verdict_o = link[NLEAF-1];
endmodule

// File: rtl/berger_out_stage.sv
module berger_out_stage #(
    parameter int           W       = 1,
    parameter bit           REG_OUT = 1'b1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    generate
        if (REG_OUT) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst) q_o <= RST_VAL;
                else     q_o <= d_i;
            end
        end else begin : g_wire
            assign q_o = d_i;
        end
    endgenerate
endmodule

// File: rtl/berger_guard.sv
module berger_guard
    import berger_pkg::*;
#(
    parameter int   DATA_W  = DEF_DATA_W,
    parameter bit   REG_OUT = 1'b1,
    localparam int  CHK_W   = $clog2(DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] enc_data_i,
    output logic [CHK_W-1:0]  enc_check_o,
    input  logic [DATA_W-1:0] rx_data_i,
    input  logic [CHK_W-1:0]  rx_check_i,
    input  logic              phase_i,
    output logic [1:0]        verdict_o
);
    logic [CHK_W-1:0] enc_cnt;
    rail_pair_t       chk_pair;

    berger_zero_count #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_enc (
        .data_i  (enc_data_i),
        .count_o (enc_cnt)
    );

    berger_checker #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_chk_path (
        .rx_data_i  (rx_data_i),
        .rx_check_i (rx_check_i),
        .phase_i    (phase_i),
        .verdict_o  (chk_pair)
    );

    berger_out_stage #(.W(CHK_W), .REG_OUT(REG_OUT), .RST_VAL('0)) u_enc_q (
        .clk (clk),
        .rst (rst),
        .d_i (enc_cnt),
        .q_o (enc_check_o)
    );

    berger_out_stage #(.W(2), .REG_OUT(REG_OUT), .RST_VAL(2'b01)) u_verdict_q (
        .clk (clk),
        .rst (rst),
        .d_i ({chk_pair.t, chk_pair.f}),
        .q_o (verdict_o)
    );
endmodule

// File: rtl/berger_guard_chk.sv
module berger_guard_chk #(
    parameter int DATA_W  = 8,
    parameter bit REG_OUT = 1'b1,
    parameter int CHK_W   = $clog2(DATA_W + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic [DATA_W-1:0] enc_data_i,
    input logic [CHK_W-1:0]  enc_check_o,
    input logic [DATA_W-1:0] rx_data_i,
    input logic [CHK_W-1:0]  rx_check_i,
    input logic              phase_i,
    input logic [1:0]        verdict_o
);
    logic rx_match;
    assign rx_match = (int'(rx_check_i) == $countones(~rx_data_i));

    generate
        if (REG_OUT) begin : g_seq
            // R1
            assert_enc_count_R1: assert property (@(posedge clk) disable iff (rst)
                1'b1 |=> int'(enc_check_o) == $countones(~$past(enc_data_i)));
            // R3
            assert_good_pair_R3: assert property (@(posedge clk) disable iff (rst)
                rx_match |=> verdict_o == {$past(phase_i), ~$past(phase_i)});
            // R4
            assert_bad_equal_R4: assert property (@(posedge clk) disable iff (rst)
                !rx_match |=> verdict_o[1] == verdict_o[0]);
            // R6
            assert_alternate_R6: assert property (@(posedge clk) disable iff (rst)
                (!$past(rst) && rx_match && $past(rx_match) && (phase_i != $past(phase_i)))
                |=> verdict_o != $past(verdict_o));
            // R7
            assert_reset_idle_R7: assert property (@(posedge clk)
                rst |=> (verdict_o == 2'b01) && (enc_check_o == '0));
        end else begin : g_comb
            // R1
            assert_enc_count_R1: assert property (@(posedge clk) disable iff (rst)
                int'(enc_check_o) == $countones(~enc_data_i));
            // R3
            assert_good_pair_R3: assert property (@(posedge clk) disable iff (rst)
                rx_match |-> verdict_o == {phase_i, ~phase_i});
            // R4
            assert_bad_equal_R4: assert property (@(posedge clk) disable iff (rst)
                !rx_match |-> verdict_o[1] == verdict_o[0]);
            // R6
            assert_alternate_R6: assert property (@(posedge clk) disable iff (rst)
                (rx_match && $past(rx_match) && (phase_i != $past(phase_i)) && !$past(rst))
                |-> verdict_o != $past(verdict_o));
        end
    endgenerate
endmodule

bind berger_guard berger_guard_chk #(
    .DATA_W  (DATA_W),
    .REG_OUT (REG_OUT)
) u_guard_chk (
    .clk         (clk),
    .rst         (rst),
    .enc_data_i  (enc_data_i),
    .enc_check_o (enc_check_o),
    .rx_data_i   (rx_data_i),
    .rx_check_i  (rx_check_i),
    .phase_i     (phase_i),
    .verdict_o   (verdict_o)
);

// File: tb/tb_berger_guard.sv
module tb_berger_guard;
    localparam int DW = 8;
    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [DW-1:0] enc_data = '0;
    logic [DW-1:0] rx_data  = '0;
    logic [CW-1:0] rx_check = '0;
    logic          phase    = 1'b0;
    logic [CW-1:0] enc_check;
    logic [1:0]    verdict;

    always #10 clk = ~clk;

    berger_guard #(.DATA_W(DW), .REG_OUT(1'b1)) dut (
        .clk         (clk),
        .rst         (rst),
        .enc_data_i  (enc_data),
        .enc_check_o (enc_check),
        .rx_data_i   (rx_data),
        .rx_check_i  (rx_check),
        .phase_i     (phase),
        .verdict_o   (verdict)
    );

    typedef struct {
        logic [CW-1:0] exp_chk;
        bit            exp_pass;
        bit            ph;
        string         enc_tag;
        string         chk_tag;
    } exp_t;

    exp_t sb[$];
    int   total = 0;
    int   bad   = 0;

    function automatic int zeros(input logic [DW-1:0] d);
        int n = 0;
        for (int i = 0; i < DW; i++) if (!d[i]) n++;
        return n;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [DW-1:0] ed, input logic [DW-1:0] rd,
                         input logic [CW-1:0] rc, input logic ph,
                         input string et, input string ct);
        exp_t e;
        @(negedge clk);
        enc_data = ed;
        rx_data  = rd;
        rx_check = rc;
        phase    = ph;
        e.exp_chk  = CW'(zeros(ed));
        e.exp_pass = (zeros(rd) == int'(rc));
        e.ph       = ph;
        e.enc_tag  = et;
        e.chk_tag  = ct;
        sb.push_back(e);
    endtask

    // monitor: one item per clock, sampled 5 ns after the edge
    initial begin
        bit         have_prev;
        bit         prev_pass;
        bit         prev_ph;
        logic [1:0] prev_v;
        exp_t       e;
        have_prev = 1'b0;
        prev_pass = 1'b0;
        prev_ph   = 1'b0;
        prev_v    = 2'b00;
        forever begin
            @(posedge clk);
            #5;
            if (sb.size() > 0) begin
                e = sb.pop_front();
                check(enc_check == e.exp_chk, e.enc_tag, int'(enc_check), int'(e.exp_chk));
                if (e.exp_pass)
                    check(verdict == {e.ph, ~e.ph}, "R3", int'(verdict), int'({e.ph, ~e.ph}));
                else
                    check(verdict[1] == verdict[0], e.chk_tag, int'(verdict), 0);
                if (have_prev && prev_pass && e.exp_pass && (prev_ph != e.ph))
                    check(verdict != prev_v, "R6", int'(verdict), int'(~prev_v));
                have_prev = 1'b1;
                prev_pass = e.exp_pass;
                prev_ph   = e.ph;
                prev_v    = verdict;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [DW-1:0]    d;
        logic [CW-1:0]    c;
        logic [DW+CW-1:0] w;
        logic [DW+CW-1:0] m;
        logic [DW+CW-1:0] v;

        // R7 reset state, inputs form a mismatching word
        repeat (3) @(posedge clk);
        #5;
        check(enc_check == 4'd0, "R7", int'(enc_check), 0);
        check(verdict == 2'b01, "R7", int'(verdict), 1);
        @(negedge clk);
        rst = 1'b0;

        // R2 extremes
        drive(8'h00, 8'h00, 4'd8, 1'b0, "R2", "R4");
        drive(8'hFF, 8'hFF, 4'd0, 1'b1, "R2", "R4");

        // R1 / R3 / R6 valid words with toggling phase
        for (int i = 0; i < 24; i++) begin
            d = DW'(i * 37 + 5);
            drive(d, d, CW'(zeros(d)), i[0], "R1", "R4");
        end

        // R4 wrong check fields
        for (int i = 0; i < 16; i++) begin
            d = DW'(i * 53 + 11);
            c = CW'(zeros(d) + 1 + (i % 7));
            drive(d, d, c, i[1], "R1", "R4");
        end

        // R5 unidirectional bursts over the 12-bit word
        for (int i = 1; i < 30; i++) begin
            d = DW'(i * 29 + 3);
            w = {CW'(zeros(d)), d};
            m = (DW+CW)'(i * 157 + 1);
            if ((w & m) != '0) begin
                v = w & ~m;
                drive(d, v[DW-1:0], v[DW+CW-1:DW], i[0], "R1", "R5");
            end
            if ((~w & m) != '0) begin
                v = w | m;
                drive(d, v[DW-1:0], v[DW+CW-1:DW], ~i[0], "R1", "R5");
            end
        end

        // R7 registered latency: old value held until the next edge
        drive(8'hFF, 8'hFF, 4'd0, 1'b0, "R2", "R4");
        drive(8'h00, 8'h00, 4'd8, 1'b1, "R2", "R4");
        #2;
        check(enc_check == 4'd0, "R7", int'(enc_check), 0);
        check(verdict == 2'b01, "R7", int'(verdict), 1);

        repeat (4) @(posedge clk);
        #7;
        check(sb.size() == 0, "R7", sb.size(), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule